// File: doc/BRIEF.md
# Viewport-Programmed Address Translation Unit

This block rewrites request addresses on two independent paths, outbound and inbound. Each path owns a small set of translation regions. Every region holds an enable, a match-mode flag, a transaction type, a 64-bit base (low and high words), a 32-bit inclusive limit and a 64-bit target. A request that falls inside an enabled region leaves the block as `target + (address - base)`, tagged with that region's type. A request that matches no region passes through unchanged, and a miss flag is raised.

Software never addresses a region directly. It first writes a selector word that names a direction and a region index. It then reads and writes one shared window of seven registers, and those accesses reach whichever region the selector names. Configuration-type regions use the same arithmetic. Their target carries the bus and device numbers, and the offset inside the window carries the function number and register offset, so the translated address is the routing word for a configuration access.

Top module: `addr_xlate_vp`

## Requirements
- R1: The selector register at offset 0x900 stores bit 31 as direction (1 = inbound, 0 = outbound) and bits 3:0 as the region index. Reading it returns exactly those bits, and all other bits read as zero.
- R2: The window registers reach the selected region only. The layout is: 0x904 type in bits 4:0; 0x908 enable in bit 31 and match-mode flag in bit 30; 0x90C base low; 0x910 base high; 0x914 limit; 0x918 target low; 0x91C target high. A read returns the selected region's stored value.
- R3: When the selector names an index at or above the region count for that direction, window reads return zero and window writes change no region.
- R4: An outbound request hits a region when the region is enabled, address bits 63:32 equal base high, and address bits 31:0 lie between base low and limit. On a hit the output address is target + (address - base), the output type is the region's type, and the miss flag is 0.
- R5: On a miss the output address equals the request address, the type is 0 and the miss flag is 1.
- R6: A disabled region never matches.
- R7: When several enabled regions match, the lowest-numbered region supplies the result.
- R8: The inbound path translates with the inbound regions by the same rules. Writes made with the selector on one direction never alter the other direction's regions.
- R9: In a configuration region whose target holds bus in bits 31:24 and device in bits 23:19, a request whose window offset holds function in bits 18:16 and a dword offset below that translates to the combined bus/device/function/offset word.
- R10: A register write changes translation only from the clock edge that captures it. During the write cycle itself the old mapping still applies.
- R11: After reset the selector is zero, every region is cleared and disabled, and every request misses.
- R12: Both ends of a window are inclusive: the base and the limit hit, while base-1 and limit+1 miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| obAddr | input | 64 | Outbound request address |
| obXAddr | output | 64 | Outbound translated address |
| obType | output | 5 | Outbound transaction type |
| obMiss | output | 1 | Outbound miss flag |
| ibAddr | input | 64 | Inbound request address |
| ibXAddr | output | 64 | Inbound translated address |
| ibType | output | 5 | Inbound transaction type |
| ibMiss | output | 1 | Inbound miss flag |

## Verification
A register write to a region and a translation through that same region can occur in the same cycle. The bench provokes this by holding an outbound address on an enabled region while it drives a write that disables the region. It judges the outcome in two places: before the capturing edge the old hit must still be visible, and after that edge the request must miss. The same collision across directions is covered as well. A write made with the selector on the inbound side must leave outbound results unchanged.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 2 * WORD_W;
  localparam int IDX_W  = 4;
  localparam int TYPE_W = 5;

  localparam logic [11:0] OFS_VIEW = 12'h900;
  localparam logic [11:0] OFS_CTL1 = 12'h904;
  localparam logic [11:0] OFS_CTL2 = 12'h908;
  localparam logic [11:0] OFS_BLO  = 12'h90C;
  localparam logic [11:0] OFS_BHI  = 12'h910;
  localparam logic [11:0] OFS_LIM  = 12'h914;
  localparam logic [11:0] OFS_TLO  = 12'h918;
  localparam logic [11:0] OFS_THI  = 12'h91C;

  typedef enum logic [2:0] {
    FLD_TYPE, FLD_CTL, FLD_BLO, FLD_BHI, FLD_LIM, FLD_TLO, FLD_THI
  } fld_e;

  typedef struct packed {
    logic              enable;
    logic              barMatch;
    logic [TYPE_W-1:0] kind;
    logic [WORD_W-1:0] baseLo;
    logic [WORD_W-1:0] baseHi;
    logic [WORD_W-1:0] limit;
    logic [WORD_W-1:0] tgtLo;
    logic [WORD_W-1:0] tgtHi;
  } region_t;

  // strobes from control to the region banks
  typedef struct packed {
    logic              wrOut;
    logic              wrIn;
    logic [IDX_W-1:0]  idx;
    fld_e              fld;
    logic [WORD_W-1:0] data;
  } strobe_t;

  function automatic logic [WORD_W-1:0] fieldRead(region_t r, fld_e f);
    logic [WORD_W-1:0] v;
    case (f)
      FLD_TYPE: v = {{(WORD_W-TYPE_W){1'b0}}, r.kind};
      FLD_CTL:  v = {r.enable, r.barMatch, {(WORD_W-2){1'b0}}};
      FLD_BLO:  v = r.baseLo;
      FLD_BHI:  v = r.baseHi;
      FLD_LIM:  v = r.limit;
      FLD_TLO:  v = r.tgtLo;
      default:  v = r.tgtHi;
    endcase
    return v;
  endfunction

  function automatic region_t fieldWrite(region_t r, fld_e f, logic [WORD_W-1:0] d);
    region_t n = r;
    case (f)
      FLD_TYPE: n.kind = d[TYPE_W-1:0];
      FLD_CTL: begin
        n.enable   = d[WORD_W-1];
        n.barMatch = d[WORD_W-2];
      end
      FLD_BLO: n.baseLo = d;
      FLD_BHI: n.baseHi = d;
      FLD_LIM: n.limit  = d;
      FLD_TLO: n.tgtLo  = d;
      default: n.tgtHi  = d;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/atu_ctrl.sv
module atu_ctrl
  import atu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [11:0]       regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  region_t           rdOut,
  input  region_t           rdIn,
  output strobe_t           st,
  output logic [IDX_W-1:0]  viewIdx,
  output logic [WORD_W-1:0] regRdata
);
  logic viewIn;
  logic winHit;
  fld_e fld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      viewIn  <= 1'b0;
      viewIdx <= '0;
    end else if (regWe && regAddr == OFS_VIEW) begin
      viewIn  <= regWdata[WORD_W-1];
      viewIdx <= regWdata[IDX_W-1:0];
    end
  end

  always_comb begin
    winHit = 1'b1;
    fld    = FLD_TYPE;
    case (regAddr)
      OFS_CTL1: fld = FLD_TYPE;
      OFS_CTL2: fld = FLD_CTL;
      OFS_BLO:  fld = FLD_BLO;
      OFS_BHI:  fld = FLD_BHI;
      OFS_LIM:  fld = FLD_LIM;
      OFS_TLO:  fld = FLD_TLO;
      OFS_THI:  fld = FLD_THI;
      default:  winHit = 1'b0;
    endcase
  end

  always_comb begin
    st.idx   = viewIdx;
    st.fld   = fld;
    st.data  = regWdata;
    st.wrOut = regWe && winHit && !viewIn;
    st.wrIn  = regWe && winHit && viewIn;
  end

  always_comb begin
    if (regAddr == OFS_VIEW)
      regRdata = {viewIn, {(WORD_W-1-IDX_W){1'b0}}, viewIdx};
    else if (winHit)
      regRdata = fieldRead(viewIn ? rdIn : rdOut, fld);
    else
      regRdata = '0;
  end
endmodule

// File: rtl/atu_region_bank.sv
module atu_region_bank
  import atu_pkg::*;
#(
  parameter int NUM   = 2,
  parameter bit IS_IN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [IDX_W-1:0]  rdIdx,
  output region_t           rdRegion,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] xAddr,
  output logic [TYPE_W-1:0] xType,
  output logic              miss
);
  region_t regs [NUM];
  logic [NUM-1:0] hitVec;
  logic wrThis;

  generate
    if (IS_IN) begin : gSelIn
      assign wrThis = st.wrIn;
    end else begin : gSelOut
      assign wrThis = st.wrOut;
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM; i++) begin
      if (!rstN)
        regs[i] <= '0;
      else if (wrThis && st.idx == IDX_W'(i))
        regs[i] <= fieldWrite(regs[i], st.fld, st.data);
    end
  end

  always_comb begin
    rdRegion = '0;
    for (int i = 0; i < NUM; i++)
      if (rdIdx == IDX_W'(i)) rdRegion = regs[i];
  end

  for (genvar g = 0; g < NUM; g++) begin : gMatch
    assign hitVec[g] = regs[g].enable
                    && reqAddr[ADDR_W-1:WORD_W] == regs[g].baseHi
                    && reqAddr[WORD_W-1:0] >= regs[g].baseLo
                    && reqAddr[WORD_W-1:0] <= regs[g].limit;
  end

  region_t win;
  logic    any;
  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        win = regs[i];
        any = 1'b1;
      end
    end
  end

  always_comb begin
    if (any) begin
      xAddr = {win.tgtHi, win.tgtLo} + (reqAddr - {win.baseHi, win.baseLo});
      xType = win.kind;
      miss  = 1'b0;
    end else begin
      xAddr = reqAddr;
      xType = '0;
      miss  = 1'b1;
    end
  end
endmodule

// File: rtl/addr_xlate_vp.sv
module addr_xlate_vp
  import atu_pkg::*;
#(
  parameter int NUM_OUT = 2,
  parameter int NUM_IN  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [11:0] regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic [63:0] obAddr,
  output logic [63:0] obXAddr,
  output logic [4:0]  obType,
  output logic        obMiss,
  input  logic [63:0] ibAddr,
  output logic [63:0] ibXAddr,
  output logic [4:0]  ibType,
  output logic        ibMiss
);
  strobe_t          st;
  logic [IDX_W-1:0] viewIdx;
  region_t          rdOut, rdIn;

  atu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .rdOut(rdOut), .rdIn(rdIn), .st(st),
    .viewIdx(viewIdx), .regRdata(regRdata)
  );

  atu_region_bank #(.NUM(NUM_OUT), .IS_IN(1'b0)) outBank_i (
    .clk(clk), .rstN(rstN), .st(st), .rdIdx(viewIdx), .rdRegion(rdOut),
    .reqAddr(obAddr), .xAddr(obXAddr), .xType(obType), .miss(obMiss)
  );

  atu_region_bank #(.NUM(NUM_IN), .IS_IN(1'b1)) inBank_i (
    .clk(clk), .rstN(rstN), .st(st), .rdIdx(viewIdx), .rdRegion(rdIn),
    .reqAddr(ibAddr), .xAddr(ibXAddr), .xType(ibType), .miss(ibMiss)
  );
endmodule

// File: rtl/addr_xlate_vp_chk.sv
module addr_xlate_vp_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [11:0] regAddr,
  input logic [31:0] regWdata,
  input logic [31:0] regRdata,
  input logic [63:0] obAddr,
  input logic [63:0] obXAddr,
  input logic [4:0]  obType,
  input logic        obMiss,
  input logic [63:0] ibAddr,
  input logic [63:0] ibXAddr,
  input logic [4:0]  ibType,
  input logic        ibMiss
);
  assert_ob_passthru_R5: assert property (@(posedge clk) disable iff (!rstN)
    obMiss |-> (obXAddr == obAddr && obType == 5'd0));

  assert_ib_passthru_R8: assert property (@(posedge clk) disable iff (!rstN)
    ibMiss |-> (ibXAddr == ibAddr && ibType == 5'd0));

  assert_view_readback_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 12'h900) |=>
      (regAddr != 12'h900 ||
       regRdata == {$past(regWdata[31]), 27'd0, $past(regWdata[3:0])}));

  assert_ob_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(regWe) && $stable(obAddr)) |->
      ($stable(obXAddr) && $stable(obMiss) && $stable(obType)));

  assert_ib_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(regWe) && $stable(ibAddr)) |->
      ($stable(ibXAddr) && $stable(ibMiss) && $stable(ibType)));
endmodule

bind addr_xlate_vp addr_xlate_vp_chk chk_i (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .obAddr(obAddr),
  .obXAddr(obXAddr), .obType(obType), .obMiss(obMiss), .ibAddr(ibAddr),
  .ibXAddr(ibXAddr), .ibType(ibType), .ibMiss(ibMiss)
);

// File: tb/addr_xlate_vp_tb_top.sv
module addr_xlate_vp_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [63:0] obAddr = '0, ibAddr = '0;
  logic [63:0] obXAddr, ibXAddr;
  logic [4:0]  obType, ibType;
  logic        obMiss, ibMiss;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  addr_xlate_vp dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .obAddr(obAddr),
    .obXAddr(obXAddr), .obType(obType), .obMiss(obMiss), .ibAddr(ibAddr),
    .ibXAddr(ibXAddr), .ibType(ibType), .ibMiss(ibMiss)
  );

  localparam logic [11:0] VIEW = 12'h900, CTL1 = 12'h904, CTL2 = 12'h908,
    BLO = 12'h90C, BHI = 12'h910, LIM = 12'h914, TLO = 12'h918, THI = 12'h91C;

  typedef struct packed {
    logic        inb;
    logic [63:0] addr;
    logic [63:0] xaddr;
    logic [4:0]  kind;
    logic        miss;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 64'h0000_0000_1005_0010, 64'h0000_0000_0315_0010, 5'd4, 1'b0}, // R9
    '{1'b0, 64'h0000_0000_2000_0004, 64'h0000_0001_8000_0004, 5'd2, 1'b0}, // R4
    '{1'b0, 64'h0000_0000_2FFF_FFFF, 64'h0000_0001_8FFF_FFFF, 5'd2, 1'b0}, // R12 limit
    '{1'b0, 64'h0000_0000_2000_0000, 64'h0000_0001_8000_0000, 5'd2, 1'b0}, // R12 base
    '{1'b0, 64'h0000_0000_3000_0000, 64'h0000_0000_3000_0000, 5'd0, 1'b1}, // R12 limit+1
    '{1'b0, 64'h0000_0001_2000_0004, 64'h0000_0001_2000_0004, 5'd0, 1'b1}, // R4 high word
    '{1'b0, 64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0FFF_FFFF, 5'd0, 1'b1}, // R5 base-1
    '{1'b1, 64'h0000_0000_0000_1234, 64'h0000_0000_4000_1234, 5'd0, 1'b0}, // R8
    '{1'b1, 64'h0000_0000_1000_0000, 64'h0000_0000_1000_0000, 5'd0, 1'b1}, // R8 limit+1
    '{1'b1, 64'h0000_0000_2000_0004, 64'h0000_0000_2000_0004, 5'd0, 1'b1}  // R8 isolation
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, {32'd0, regRdata}, {32'd0, exp});
  endtask

  task automatic obChk(input string tag, input logic [63:0] a, input logic [63:0] ex,
                       input logic [4:0] ty, input logic ms);
    obAddr = a;
    #1;
    check(tag, {obXAddr, 3'd0, obType, 7'd0, obMiss}, {ex, 3'd0, ty, 7'd0, ms});
  endtask

  task automatic ibChk(input string tag, input logic [63:0] a, input logic [63:0] ex,
                       input logic [4:0] ty, input logic ms);
    ibAddr = a;
    #1;
    check(tag, {ibXAddr, 3'd0, ibType, 7'd0, ibMiss}, {ex, 3'd0, ty, 7'd0, ms});
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    rdChk("R11 selector", VIEW, 32'h0);
    rdChk("R11 ctl2", CTL2, 32'h0);
    @(negedge clk);
    obChk("R11 ob miss", 64'h0, 64'h0, 5'd0, 1'b1);
    ibChk("R11 ib miss", 64'h0, 64'h0, 5'd0, 1'b1);

    // outbound region 0: config type 0, bus 3 dev 2
    wr(VIEW, 32'h0000_0000);
    wr(CTL1, 32'd4);
    wr(BLO, 32'h1000_0000); wr(BHI, 32'h0); wr(LIM, 32'h1007_FFFF);
    wr(TLO, 32'h0310_0000); wr(THI, 32'h0);
    wr(CTL2, 32'h8000_0000);
    // outbound region 1: I/O type
    wr(VIEW, 32'h0000_0001);
    wr(CTL1, 32'd2);
    wr(BLO, 32'h2000_0000); wr(BHI, 32'h0); wr(LIM, 32'h2FFF_FFFF);
    wr(TLO, 32'h8000_0000); wr(THI, 32'h1);
    wr(CTL2, 32'h8000_0000);
    // inbound region 0: memory
    wr(VIEW, 32'h8000_0000);
    wr(CTL1, 32'd0);
    wr(BLO, 32'h0); wr(BHI, 32'h0); wr(LIM, 32'h0FFF_FFFF);
    wr(TLO, 32'h4000_0000); wr(THI, 32'h0);
    wr(CTL2, 32'h8000_0000);

    // table walk: R4 R5 R8 R9 R12
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      if (VECS[v].inb)
        ibChk($sformatf("R4/R8/R12 vector %0d", v), VECS[v].addr, VECS[v].xaddr,
              VECS[v].kind, VECS[v].miss);
      else
        obChk($sformatf("R4/R5/R9/R12 vector %0d", v), VECS[v].addr, VECS[v].xaddr,
              VECS[v].kind, VECS[v].miss);
    end

    // R10: write and translation in the same cycle
    wr(VIEW, 32'h0000_0001);
    @(negedge clk);
    regWe = 1'b1; regAddr = CTL2; regWdata = 32'h0;
    obChk("R10 old map during write", 64'h2000_0004, 64'h1_8000_0004, 5'd2, 1'b0);
    @(negedge clk);
    regWe = 1'b0;
    obChk("R10 new map after edge", 64'h2000_0004, 64'h2000_0004, 5'd0, 1'b1);

    // R7 / R6: overlapping regions
    wr(CTL1, 32'd2);
    wr(BLO, 32'h1000_0000); wr(LIM, 32'h1000_FFFF);
    wr(TLO, 32'h5000_0000); wr(THI, 32'h0);
    wr(CTL2, 32'h8000_0000);
    @(negedge clk);
    obChk("R7 lowest index wins", 64'h1000_0010, 64'h0310_0010, 5'd4, 1'b0);
    wr(VIEW, 32'h0000_0000);
    wr(CTL2, 32'h0);
    @(negedge clk);
    obChk("R6 disabled region skipped", 64'h1000_0010, 64'h5000_0010, 5'd2, 1'b0);

    // R3: index beyond region count
    wr(VIEW, 32'h0000_0003);
    wr(LIM, 32'h0000_1234);
    rdChk("R3 missing region reads zero", LIM, 32'h0);
    wr(VIEW, 32'h0000_0001);
    rdChk("R3 region 1 limit untouched", LIM, 32'h1000_FFFF);

    // R2: window read-back for the selected region
    rdChk("R2 ob1 type", CTL1, 32'd2);
    rdChk("R2 ob1 target low", TLO, 32'h5000_0000);
    wr(VIEW, 32'h8000_0000);
    wr(CTL2, 32'hC000_0000);
    rdChk("R2 ib0 ctl2 with match flag", CTL2, 32'hC000_0000);
    rdChk("R2 ib0 target low", TLO, 32'h4000_0000);
    // R8: inbound writes leave outbound intact
    @(negedge clk);
    obChk("R8 outbound unchanged", 64'h1000_0010, 64'h5000_0010, 5'd2, 1'b0);
    ibChk("R8 inbound still maps", 64'h0FFF_FFFF, 64'h4FFF_FFFF, 5'd0, 1'b0);

    // R1: selector read-back
    wr(VIEW, 32'h8000_000F);
    rdChk("R1 selector in/15", VIEW, 32'h8000_000F);
    wr(VIEW, 32'h7FFF_FFF1);
    rdChk("R1 selector masked", VIEW, 32'h0000_0001);

    summary();
  end
endmodule